// File: doc/BRIEF.md
# Preamble-Trained Read Capture Skew Selector

This block sits on the host side of a quad-lane, double-data-rate serial memory read path. The host stops driving the four IO lanes during the latency cycles. In the last four clock cycles before the first data, the memory drives a known training pattern on those lanes. The host's delay line provides several copies of the lane bundle, each with a different delay. Every copy ("tap") is sampled on both clock edges.

While the sequencer marks the preamble window, the block checks every tap against the expected pattern. At the end of the window it picks the middle of the longest contiguous run of matching taps. It then keeps that tap for the data phase of the same read. Every read trains again, so the capture point follows drift in temperature, voltage and board delay. Reads that carry no preamble leave the previous choice in place.

Top module: `skew_trainer`

## Requirements
- R1: After reset, `tapSel` equals NUM_TAPS/2, `locked` is 0, `rdValid` is 0 and `rdData` is 0.
- R2: A tap passes only when all four lanes match the expected bit on both edges of all four preamble beats. Beat b (0 first) expects `expPattern[7-2b]` on the rising sample and `expPattern[6-2b]` on the falling sample. One wrong bit on any single lane fails the tap.
- R3: When at least one tap passes, the new `tapSel` is start + (length-1)/2 of the longest contiguous run of passing taps. For even lengths this is the lower of the two middle taps.
- R4: When two or more runs tie for longest, the run with the lowest tap index wins.
- R5: When no tap passes, `locked` goes to 0 and `tapSel` keeps its previous value.
- R6: The new `tapSel` and `locked` are visible in the first cycle after the fourth preamble beat. This is the first data cycle.
- R7: In each cycle with `dataPhase` high, the block captures the selected tap. On the next cycle `rdData` = {rising nibble, falling nibble} of that tap and `rdValid` is 1. In the cycle after `dataPhase` is low, `rdValid` is 0.
- R8: `tapSel` does not change during the data phase, even when the tap inputs change every cycle.
- R9: A preamble window with `dlpEnable` low is ignored. `tapSel` and `locked` keep their values.
- R10: If the window ends after fewer than four beats, `locked` goes to 0 one cycle after the window ends, and `tapSel` keeps its value.
- R11: The expected pattern comes from the `expPattern` input, so any 8-bit value can be used. The default use is 34h.
- R12: Each read trains again from scratch, so the tap can move from one read to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dlpEnable | input | 1 | The memory drives a training preamble on this read |
| preambleWin | input | 1 | High during the preamble beats, from the sequencer |
| dataPhase | input | 1 | High during data cycles of the read |
| expPattern | input | 8 | Expected per-lane pattern, first beat's rising bit in the MSB |
| tapRise | input | NUM_TAPS*4 | Rising-edge samples, 4 lanes per tap, tap 0 in the low bits |
| tapFall | input | NUM_TAPS*4 | Falling-edge samples, same layout |
| tapSel | output | $clog2(NUM_TAPS) | Selected capture tap |
| locked | output | 1 | The last training found a passing tap |
| rdData | output | 8 | Captured byte: rising nibble high, falling nibble low |
| rdValid | output | 1 | `rdData` holds a byte captured in the previous cycle |

## Verification
The first group of checks uses pass masks that the bench builds: a run in the middle, two runs of different length, two runs of equal length, a single tap at the array edge, and no passing tap at all. Together these separate center selection from tie-breaking and from the failure path. Each failing tap differs from the pattern in only one bit, on a lane that depends on the tap. This catches a compare that skips lanes or edges. A second pattern, A5h, checks that the beat and edge bit order is not fixed to the default pattern. Disabled and short windows confirm that training does not start, or is abandoned, without disturbing the held tap. Multi-cycle data phases with tap inputs that change each cycle confirm that the tap is held and that the byte is assembled in the right order.

// File: rtl/skew_trainer_pkg.sv
package skew_trainer_pkg;

  // Preamble length in clock cycles; each beat carries two edges per lane.
  localparam int PRE_BEATS = 4;
  localparam int BEAT_W    = $clog2(PRE_BEATS);
  localparam int PAT_W     = 2 * PRE_BEATS;

  typedef enum logic [1:0] {
    TR_IDLE,
    TR_TRAIN,
    TR_WAIT_END
  } trainState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              firstBeat;  // restart the per-tap fail record
    logic              compare;    // compare this beat's samples
    logic [BEAT_W-1:0] beatIdx;    // which beat of the preamble
    logic              evaluate;   // last beat: choose the tap now
    logic              abort;      // window ended early
  } trainCtrl_t;

endpackage

// File: rtl/tap_window_pick.sv
module tap_window_pick #(
  parameter int NUM_TAPS = 8,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int CNT_W   = $clog2(NUM_TAPS + 1)
) (
  input  logic [NUM_TAPS-1:0] passVec,
  output logic                found,
  output logic [TAP_W-1:0]    center
);

  logic [CNT_W-1:0] runLen, runStart, bestLen, bestStart, mid;

  // Scan upward; strict comparison keeps the lowest run on ties.
  always_comb begin
    runLen    = '0;
    runStart  = '0;
    bestLen   = '0;
    bestStart = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (passVec[i]) begin
        if (runLen == '0) runStart = CNT_W'(i);
        runLen = runLen + CNT_W'(1);
        if (runLen > bestLen) begin
          bestLen   = runLen;
          bestStart = runStart;
        end
      end else begin
        runLen = '0;
      end
    end
    found = (bestLen != '0);
    mid   = found ? (bestStart + ((bestLen - CNT_W'(1)) >> 1)) : '0;
    center = TAP_W'(mid);
  end

endmodule

// File: rtl/skew_trainer_ctrl.sv
module skew_trainer_ctrl
  import skew_trainer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dlpEnable,
  input  logic       preambleWin,
  output trainCtrl_t ctrl
);

  trainState_e       state;
  logic [BEAT_W-1:0] beatCnt;
  logic              winGo;

  assign winGo = preambleWin && dlpEnable;

  always_comb begin
    ctrl = '0;
    case (state)
      TR_IDLE: begin
        if (winGo) begin
          ctrl.firstBeat = 1'b1;
          ctrl.compare   = 1'b1;
          ctrl.beatIdx   = '0;
        end
      end
      TR_TRAIN: begin
        if (winGo) begin
          ctrl.compare  = 1'b1;
          ctrl.beatIdx  = beatCnt;
          ctrl.evaluate = (beatCnt == BEAT_W'(PRE_BEATS - 1));
        end else begin
          ctrl.abort = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TR_IDLE;
      beatCnt <= '0;
    end else begin
      case (state)
        TR_IDLE: begin
          if (winGo) begin
            state   <= TR_TRAIN;
            beatCnt <= BEAT_W'(1);
          end
        end
        TR_TRAIN: begin
          if (!winGo) begin
            state   <= TR_IDLE;
            beatCnt <= '0;
          end else if (beatCnt == BEAT_W'(PRE_BEATS - 1)) begin
            state   <= TR_WAIT_END;
            beatCnt <= '0;
          end else begin
            beatCnt <= beatCnt + BEAT_W'(1);
          end
        end
        TR_WAIT_END: begin
          // Beats past the fourth are ignored until the window drops.
          if (!preambleWin) state <= TR_IDLE;
        end
        default: state <= TR_IDLE;
      endcase
    end
  end

  // R10: an early end of the window never comes with a tap decision.
  p_abort_not_eval_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.abort |-> !ctrl.evaluate);

  // R6: the decision beat is followed by a wait for the window to end.
  p_eval_then_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.evaluate |=> !ctrl.compare);

endmodule

// File: rtl/skew_trainer_dp.sv
module skew_trainer_dp
  import skew_trainer_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  parameter int LANES    = 4,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int BUS_W   = NUM_TAPS * LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  trainCtrl_t         ctrl,
  input  logic               dataPhase,
  input  logic [PAT_W-1:0]   expPattern,
  input  logic [BUS_W-1:0]   tapRise,
  input  logic [BUS_W-1:0]   tapFall,
  output logic [TAP_W-1:0]   tapSel,
  output logic               locked,
  output logic [2*LANES-1:0] rdData,
  output logic               rdValid
);

  logic [NUM_TAPS-1:0] failVec, failNow, mismatch;
  logic                expRise, expFall;
  logic                pickFound;
  logic [TAP_W-1:0]    pickCenter;

  // Beat b uses pattern bits 2*(PRE_BEATS-1-b)+1 (rising) and +0 (falling).
  always_comb begin
    expRise = expPattern[2 * (PRE_BEATS - 1 - int'(ctrl.beatIdx)) + 1];
    expFall = expPattern[2 * (PRE_BEATS - 1 - int'(ctrl.beatIdx))];
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tapCmp
    assign mismatch[t] =
      (tapRise[t*LANES +: LANES] != {LANES{expRise}}) ||
      (tapFall[t*LANES +: LANES] != {LANES{expFall}});
    assign failNow[t] = ctrl.firstBeat ? mismatch[t] : (failVec[t] | mismatch[t]);
  end

  tap_window_pick #(.NUM_TAPS(NUM_TAPS)) u_pick (
    .passVec (~failNow),
    .found   (pickFound),
    .center  (pickCenter)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failVec <= '0;
      tapSel  <= TAP_W'(NUM_TAPS / 2);
      locked  <= 1'b0;
    end else begin
      if (ctrl.compare) failVec <= failNow;
      if (ctrl.evaluate) begin
        locked <= pickFound;
        if (pickFound) tapSel <= pickCenter;
      end else if (ctrl.abort) begin
        locked <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= dataPhase;
      if (dataPhase)
        rdData <= {tapRise[int'(tapSel)*LANES +: LANES],
                   tapFall[int'(tapSel)*LANES +: LANES]};
    end
  end

  // R8: the tap moves only right after a decision beat.
  p_tap_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.evaluate |=> $stable(tapSel));

  // R3: a chosen center always lies on a passing tap.
  p_center_passes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.evaluate && pickFound) |-> !failNow[pickCenter]);

  // R5: lock only comes from a decision.
  p_lock_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(ctrl.evaluate));

endmodule

// File: rtl/skew_trainer.sv
module skew_trainer
  import skew_trainer_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  parameter int LANES    = 4,
  localparam int TAP_W   = $clog2(NUM_TAPS),
  localparam int BUS_W   = NUM_TAPS * LANES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dlpEnable,
  input  logic               preambleWin,
  input  logic               dataPhase,
  input  logic [PAT_W-1:0]   expPattern,
  input  logic [BUS_W-1:0]   tapRise,
  input  logic [BUS_W-1:0]   tapFall,
  output logic [TAP_W-1:0]   tapSel,
  output logic               locked,
  output logic [2*LANES-1:0] rdData,
  output logic               rdValid
);

  trainCtrl_t ctrl;

  skew_trainer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .dlpEnable   (dlpEnable),
    .preambleWin (preambleWin),
    .ctrl        (ctrl)
  );

  skew_trainer_dp #(.NUM_TAPS(NUM_TAPS), .LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .dataPhase  (dataPhase),
    .expPattern (expPattern),
    .tapRise    (tapRise),
    .tapFall    (tapFall),
    .tapSel     (tapSel),
    .locked     (locked),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  // R9: with training disabled the tap cannot move.
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dlpEnable |=> $stable(tapSel));

  // R7: each data cycle yields a valid byte on the next cycle.
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataPhase |=> rdValid);

endmodule

// File: tb/skew_trainer_test.sv
module skew_trainer_test;

  localparam int NT = 8;
  localparam int LN = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          dlpEnable, preambleWin, dataPhase;
  logic [7:0]    expPattern;
  logic [NT*LN-1:0] tapRise, tapFall;
  logic [2:0]    tapSel;
  logic          locked;
  logic [7:0]    rdData;
  logic          rdValid;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  skew_trainer #(.NUM_TAPS(NT), .LANES(LN)) uut (
    .clk, .rstN, .dlpEnable, .preambleWin, .dataPhase, .expPattern,
    .tapRise, .tapFall, .tapSel, .locked, .rdData, .rdValid
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Preamble beat: passing taps carry the exact bits; failing taps have one
  // lane (index = tap mod 4) flipped on the falling edge of beat 1.
  task automatic drivePreamble(input logic [7:0] mask, input logic [7:0] pat, input int b);
    for (int t = 0; t < NT; t++) begin
      logic r, f;
      logic [LN-1:0] fv;
      r  = pat[7 - 2*b];
      f  = pat[6 - 2*b];
      fv = {LN{f}};
      if (!mask[t] && b == 1) fv[t % LN] = ~fv[t % LN];
      tapRise[t*LN +: LN] = {LN{r}};
      tapFall[t*LN +: LN] = fv;
    end
  endtask

  // Data beat: tap t gives rising nibble t^k, falling nibble ~(t^k).
  task automatic driveData(input int k);
    for (int t = 0; t < NT; t++) begin
      tapRise[t*LN +: LN] = 4'(t ^ k);
      tapFall[t*LN +: LN] = ~4'(t ^ k);
    end
  endtask

  task automatic runRead(input string tag, input logic [7:0] mask, input logic [7:0] pat,
                         input logic dlp, input int beats, input int dCycles,
                         input int expTap, input int expLock);
    @(negedge clk);
    expPattern = pat;
    dlpEnable  = dlp;
    for (int b = 0; b < beats; b++) begin
      if (b > 0) @(negedge clk);
      preambleWin = 1'b1;
      drivePreamble(mask, pat, b);
    end
    @(negedge clk);
    preambleWin = 1'b0;
    if (beats < 4) @(negedge clk);  // early end is resolved one cycle later
    check(tag, "tapSel", tapSel, expTap);
    check(tag, "locked", locked, expLock);
    for (int k = 0; k < dCycles; k++) begin
      dataPhase = 1'b1;
      driveData(k);
      @(negedge clk);
      check(tag, "rdValid", rdValid, 1);
      check(tag, "rdData", rdData, {4'(expTap ^ k), ~4'(expTap ^ k)});
      check(tag, "tapSel hold R8", tapSel, expTap);
    end
    dataPhase = 1'b0;
    @(negedge clk);
    check(tag, "rdValid low R7", rdValid, 0);
    dlpEnable = 1'b1;
  endtask

  task automatic testReset();
    check("R1", "tapSel", tapSel, NT / 2);
    check("R1", "locked", locked, 0);
    check("R1", "rdValid", rdValid, 0);
    check("R1", "rdData", rdData, 0);
  endtask

  task automatic testMiddleRun();   // taps 2..5 pass, one-bit faults elsewhere
    runRead("R2 R3 R6 R7", 8'b0011_1100, 8'h34, 1'b1, 4, 2, 3, 1);
  endtask
  task automatic testLongerRun();   // runs 0..1 and 5..7
    runRead("R3", 8'b1110_0011, 8'h34, 1'b1, 4, 1, 6, 1);
  endtask
  task automatic testTie();         // runs 1..2 and 5..6
    runRead("R4", 8'b0110_0110, 8'h34, 1'b1, 4, 1, 1, 1);
  endtask
  task automatic testNoPass();
    runRead("R5 R8", 8'b0000_0000, 8'h34, 1'b1, 4, 3, 1, 0);
  endtask
  task automatic testOtherPattern();
    runRead("R11", 8'b1111_1111, 8'hA5, 1'b1, 4, 1, 3, 1);
  endtask
  task automatic testDisabled();
    runRead("R9", 8'b1000_0000, 8'h34, 1'b0, 4, 1, 3, 1);
  endtask
  task automatic testShortWindow();
    runRead("R10", 8'b1111_1111, 8'h34, 1'b1, 2, 1, 3, 0);
  endtask
  task automatic testRetrain();
    runRead("R12", 8'b1100_0000, 8'h34, 1'b1, 4, 1, 6, 1);
    runRead("R12", 8'b0000_0001, 8'h34, 1'b1, 4, 1, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rstN = 1'b0; dlpEnable = 1'b1; preambleWin = 1'b0; dataPhase = 1'b0;
    expPattern = 8'h34; tapRise = '0; tapFall = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMiddleRun();
    testLongerRun();
    testTie();
    testNoPass();
    testOtherPattern();
    testDisabled();
    testShortWindow();
    testRetrain();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule